// File: doc/BRIEF.md
# Parallel Bootstrap RAM Loader

This block fills an on-chip RAM with a program fetched byte by byte from an external parallel source, such as an EPROM or a host port, and then starts execution of that program. Every step of the sequence advances only on a machine-cycle enable, `mc_en`. Each byte takes a fixed load cycle of `CYCLE_LEN` machine cycles. During that cycle the loader drives the byte index onto the external address bus, toggles a handshake output, captures the data byte once the handshake input agrees with the handshake output, and checks a stop pin before it commits the byte to RAM. When the two handshake lines are tied together, each load cycle runs at the full fixed rate. When a host drives the handshake input, the cycle stalls at the data-capture point until the host answers.

Loading ends in one of two ways: the stop pin reads low at the commit point, or the byte at the top RAM address has been written. In both cases the loader emits a one-clock start pulse that carries the fixed entry address, which is the base of the load area. After reset, the loader first samples an unsecure strap. If the strap shows the part is secured, no byte is ever loaded, and an error LED output blinks for as long as the part stays in that state.

Top module: `boot_ram_loader`

## Requirements
- R1: With `secure_open` = 0 at the first machine cycle after reset, the loader makes no RAM write and no start pulse, and `err_led` toggles once every `FLASH_HALF` machine cycles.
- R2: The n-th committed byte (n counted from 0) is written to `ram_addr` = `LOAD_BASE` + n, with the `data_in` value captured while `ext_addr` = n. Bits of `ext_addr` at position `RAM_AW` and above are 0.
- R3: `keep_loading` passes through a 2-flop synchronizer and is sampled at machine cycle `COMMIT_AT` (default 32) of every load cycle. A 0 there ends loading, and that cycle's byte is not written. With `mc_en` high on every clock, a drop seen at the clock where the cycle reaches machine cycle 30 still stops that cycle, and a drop one clock later does not.
- R4: After the byte at `RAM_TOP` is written, loading ends at the last machine cycle of that load cycle, with no further write.
- R5: Loading ends with exactly one start pulse: `go_pulse` high for one clock, with `go_addr` = `LOAD_BASE`. The pulse appears one clock after the end decision.
- R6: With `hs_in` tied to `hs_out` and `mc_en` high on every clock, consecutive RAM writes are exactly `CYCLE_LEN` (49) clocks apart.
- R7: `hs_out` toggles once per load cycle, at machine cycle `TOGGLE_AT` (5). Data is captured at machine cycle `SAMPLE_AT` (16) only when the synchronized `hs_in` equals `hs_out`. Otherwise the cycle stalls there, and a handshake that never matches means no byte is ever written.
- R8: The load sequence advances only on clocks where `mc_en` is high. With `mc_en` high on one clock in three, writes are 3 × `CYCLE_LEN` clocks apart.
- R9: `err_led` stays 0 throughout a load with `secure_open` = 1.
- R10: Synchronous active-high `rst` returns the loader to the security check, with `ram_we`, `go_pulse`, `hs_out`, `err_led` and `ext_addr` all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mc_en | input | 1 | Machine-cycle enable |
| secure_open | input | 1 | 1 = loading allowed, 0 = secured |
| keep_loading | input | 1 | Stop pin, 0 ends loading |
| data_in | input | DATA_W | Byte from the external source |
| hs_in | input | 1 | Handshake input from the source |
| ext_addr | output | EXT_AW | Byte index to the external memory |
| hs_out | output | 1 | Handshake output, toggles per cycle |
| ram_we | output | 1 | RAM write strobe, one clock |
| ram_addr | output | RAM_AW | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| err_led | output | 1 | Blinking error indicator when secured |
| go_pulse | output | 1 | One-clock start-execution pulse |
| go_addr | output | RAM_AW | Entry address given with the pulse |

## Verification
The bench sweeps the stop pin over every byte position and sets the late-drop boundary at machine cycle 30 against machine cycle 31. A loader that sampled the pin at the wrong point, or that wrote the byte before checking the pin, would end with one byte too many or one too few. A small RAM window checks the full condition, the entry address and the timing of the pulse after the last write. An off-by-one top compare would write past the window or stop short of it. The bench also checks the per-cycle interval, both with the lines tied and with a sparse enable, and checks the toggle-to-write distance. A cycle counter that ran on the raw clock, or a handshake that toggled at the wrong point, shows up as a wrong interval. A slow host and a host that never answers test the stall at the data-capture point. A loader that ignored the handshake would write during the stall. The secured strap checks that nothing is written and that the blink half-period is exact.

// File: rtl/bl_pkg.sv
package bl_pkg;
    typedef enum logic [2:0] {
        ST_CHECK = 3'd0,
        ST_LOAD  = 3'd1,
        ST_GO    = 3'd2,
        ST_HALT  = 3'd3,
        ST_FLASH = 3'd4
    } bl_state_e;
endpackage

// File: rtl/bl_sync.sv
module bl_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= chain_d;
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/bl_phase_timer.sv
// Position counter inside one load cycle; holds while stalled, wraps at LEN-1.
module bl_phase_timer #(
    parameter int LEN = 49,
    parameter int CW  = $clog2(LEN)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          adv,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] LAST = CW'(LEN - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)              cnt_d = '0;
        else if (adv) begin
            if (cnt_q == LAST)  cnt_d = '0;
            else                cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/bl_flasher.sv
// Error indicator: toggles after every HALF enabled ticks.
module bl_flasher #(
    parameter int HALF = 65536,
    parameter int CW   = (HALF > 1) ? $clog2(HALF) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    output logic led
);
    localparam logic [CW-1:0] WRAP = CW'(HALF - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          led;
    } fl_t;

    fl_t fl_d, fl_q;

    always_comb begin
        fl_d = fl_q;
        if (en) begin
            if (fl_q.cnt == WRAP) begin
                fl_d.cnt = '0;
                fl_d.led = ~fl_q.led;
            end else begin
                fl_d.cnt = fl_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) fl_q <= '{cnt: '0, led: 1'b0};
        else     fl_q <= fl_d;
    end

    assign led = fl_q.led;
endmodule

// File: rtl/boot_ram_loader.sv
module boot_ram_loader
    import bl_pkg::*;
#(
    parameter int RAM_AW     = 8,
    parameter int EXT_AW     = 11,
    parameter int DATA_W     = 8,
    parameter int LOAD_BASE  = 'h50,
    parameter int RAM_TOP    = 'hFF,
    parameter int CYCLE_LEN  = 49,
    parameter int TOGGLE_AT  = 5,
    parameter int SAMPLE_AT  = 16,
    parameter int COMMIT_AT  = 32,
    parameter int FLASH_HALF = 65536
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mc_en,
    input  logic              secure_open,
    input  logic              keep_loading,
    input  logic [DATA_W-1:0] data_in,
    input  logic              hs_in,
    output logic [EXT_AW-1:0] ext_addr,
    output logic              hs_out,
    output logic              ram_we,
    output logic [RAM_AW-1:0] ram_addr,
    output logic [DATA_W-1:0] ram_wdata,
    output logic              err_led,
    output logic              go_pulse,
    output logic [RAM_AW-1:0] go_addr
);
    localparam int              CW     = $clog2(CYCLE_LEN);
    localparam logic [RAM_AW-1:0] BASE_A = RAM_AW'(LOAD_BASE);
    localparam logic [RAM_AW-1:0] TOP_A  = RAM_AW'(RAM_TOP);
    localparam logic [CW-1:0]   P_TOG  = CW'(TOGGLE_AT);
    localparam logic [CW-1:0]   P_SMP  = CW'(SAMPLE_AT);
    localparam logic [CW-1:0]   P_CMT  = CW'(COMMIT_AT);
    localparam logic [CW-1:0]   P_END  = CW'(CYCLE_LEN - 1);

    typedef struct packed {
        bl_state_e         st;
        logic [RAM_AW-1:0] off;
        logic              hs;
        logic [DATA_W-1:0] dat;
        logic              we;
        logic              go;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    // synchronized stop pin and handshake input
    logic keep_s, hs_s;
    bl_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({keep_loading, hs_in}),
        .q   ({keep_s, hs_s})
    );

    // phase within the current load cycle
    logic          run, stall, step;
    logic [CW-1:0] phase;

    assign run   = (ctl_q.st == ST_LOAD);
    assign stall = run && (phase == P_SMP) && (hs_s != ctl_q.hs);
    assign step  = run && mc_en && !stall;

    bl_phase_timer #(.LEN(CYCLE_LEN), .CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (!run),
        .adv   (step),
        .cnt   (phase)
    );

    bl_flasher #(.HALF(FLASH_HALF)) u_flash (
        .clk (clk),
        .rst (rst),
        .en  (mc_en && (ctl_q.st == ST_FLASH)),
        .led (err_led)
    );

    logic [RAM_AW-1:0] cur_addr;
    assign cur_addr = BASE_A + ctl_q.off;

    always_comb begin
        ctl_d    = ctl_q;
        ctl_d.we = 1'b0;
        ctl_d.go = 1'b0;
        unique case (ctl_q.st)
            ST_CHECK: begin
                if (mc_en) ctl_d.st = secure_open ? ST_LOAD : ST_FLASH;
            end
            ST_LOAD: begin
                if (step) begin
                    if (phase == P_TOG) ctl_d.hs  = ~ctl_q.hs;
                    if (phase == P_SMP) ctl_d.dat = data_in;
                    if (phase == P_CMT) begin
                        if (!keep_s) ctl_d.st = ST_GO;
                        else         ctl_d.we = 1'b1;
                    end
                    if (phase == P_END) begin
                        if (cur_addr == TOP_A) ctl_d.st  = ST_GO;
                        else                   ctl_d.off = ctl_q.off + 1'b1;
                    end
                end
            end
            ST_GO: begin
                ctl_d.go = 1'b1;
                ctl_d.st = ST_HALT;
            end
            ST_HALT:  ;
            ST_FLASH: ;
            default:  ctl_d.st = ST_CHECK;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '{st: ST_CHECK, off: '0, hs: 1'b0, dat: '0, we: 1'b0, go: 1'b0};
        else     ctl_q <= ctl_d;
    end

    generate
        if (EXT_AW > RAM_AW) begin : g_pad
            assign ext_addr = {{(EXT_AW - RAM_AW){1'b0}}, ctl_q.off};
        end else begin : g_cut
            assign ext_addr = ctl_q.off[EXT_AW-1:0];
        end
    endgenerate

    assign hs_out    = ctl_q.hs;
    assign ram_we    = ctl_q.we;
    assign ram_addr  = cur_addr;
    assign ram_wdata = ctl_q.dat;
    assign go_pulse  = ctl_q.go;
    assign go_addr   = BASE_A;
endmodule

// File: rtl/bl_checker.sv
module bl_checker #(
    parameter int RAM_AW    = 8,
    parameter int EXT_AW    = 11,
    parameter int LOAD_BASE = 'h50,
    parameter int RAM_TOP   = 'hFF
) (
    input logic              clk,
    input logic              rst,
    input logic              mc_en,
    input logic [EXT_AW-1:0] ext_addr,
    input logic              hs_out,
    input logic              ram_we,
    input logic [RAM_AW-1:0] ram_addr,
    input logic              err_led,
    input logic              go_pulse,
    input logic [RAM_AW-1:0] go_addr
);
    localparam logic [RAM_AW-1:0] BASE_A = RAM_AW'(LOAD_BASE);
    localparam logic [RAM_AW-1:0] TOP_A  = RAM_AW'(RAM_TOP);

    a_r1_led_quiet: assert property (@(posedge clk) disable iff (rst)
        err_led |-> (!ram_we && !go_pulse));

    a_r2_addr_tracks_ext: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr == BASE_A + ext_addr[RAM_AW-1:0]));

    a_r2_in_window: assert property (@(posedge clk) disable iff (rst)
        ram_we |-> (ram_addr >= BASE_A && ram_addr <= TOP_A));

    a_r4_no_write_after_go: assert property (@(posedge clk) disable iff (rst)
        go_pulse |=> !ram_we);

    a_r5_go_single: assert property (@(posedge clk) disable iff (rst)
        go_pulse |=> !go_pulse);

    a_r5_go_entry: assert property (@(posedge clk) disable iff (rst)
        go_pulse |-> (go_addr == BASE_A));

    a_r7_we_one_clock: assert property (@(posedge clk) disable iff (rst)
        ram_we |=> !ram_we);

    a_r8_hs_on_mc: assert property (@(posedge clk) disable iff (rst)
        !$stable(hs_out) |-> $past(mc_en));
endmodule

bind boot_ram_loader bl_checker #(
    .RAM_AW(RAM_AW), .EXT_AW(EXT_AW), .LOAD_BASE(LOAD_BASE), .RAM_TOP(RAM_TOP)
) u_chk (
    .clk(clk), .rst(rst), .mc_en(mc_en), .ext_addr(ext_addr), .hs_out(hs_out),
    .ram_we(ram_we), .ram_addr(ram_addr), .err_led(err_led),
    .go_pulse(go_pulse), .go_addr(go_addr)
);

// File: tb/boot_ram_loader_test.sv
`timescale 1ns/1ps
module boot_ram_loader_test;
    localparam int BASE = 'h50;
    localparam int TOP  = 'h57;
    localparam int NB   = TOP - BASE + 1;
    localparam int HALF = 4;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst = 1'b1, secure_open = 1'b1, keep_loading = 1'b1, hs_in, mc_en;
    logic [7:0]  data_in;
    logic [10:0] ext_addr;
    logic        hs_out, ram_we, err_led, go_pulse;
    logic [7:0]  ram_addr, ram_wdata, go_addr;

    boot_ram_loader #(.RAM_TOP(TOP), .FLASH_HALF(HALF)) uut (
        .clk(clk), .rst(rst), .mc_en(mc_en), .secure_open(secure_open),
        .keep_loading(keep_loading), .data_in(data_in), .hs_in(hs_in),
        .ext_addr(ext_addr), .hs_out(hs_out), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .err_led(err_led), .go_pulse(go_pulse), .go_addr(go_addr)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37 + 11) ^ 'h5A);
    endfunction

    int n_chk = 0, n_bad = 0;
    task automatic chk(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // enable divider, source emulation
    int clk_n = 0, div = 1, div_cnt = 0, hs_mode = 0, hs_dly = 1;
    logic [63:0] hist = '0;
    always @(posedge clk) begin
        clk_n++;
        div_cnt <= (div_cnt + 1 >= div) ? 0 : div_cnt + 1;
        hist    <= {hist[62:0], hs_out};
    end
    assign mc_en   = (div_cnt == 0);
    assign data_in = pat(int'(ext_addr[7:0]));
    always_comb begin
        case (hs_mode)
            0:       hs_in = hs_out;
            1:       hs_in = hist[hs_dly-1];
            default: hs_in = ~hs_out;
        endcase
    end

    // monitor
    int wr_cnt, go_cnt, go_clk, last_wr, exp_iv, led_tog, last_led, hs_tog, last_hs;
    logic led_prev, hs_prev;
    always @(negedge clk) begin
        if (!rst) begin
            if (ram_we) begin
                chk(int'(ram_addr) == BASE + wr_cnt, "R2 address", ram_addr, BASE + wr_cnt);
                chk(ram_wdata == pat(wr_cnt), "R2 data", ram_wdata, pat(wr_cnt));
                chk(ext_addr[10:8] == 3'd0, "R2 upper address bits", ext_addr[10:8], 0);
                chk(!err_led, "R9 led during load", err_led, 0);
                if (wr_cnt > 0 && exp_iv > 0)
                    chk(clk_n - last_wr == exp_iv, "R6/R8 write interval", clk_n - last_wr, exp_iv);
                if (wr_cnt > 0 && exp_iv < 0)
                    chk(clk_n - last_wr > 49, "R7 stalled interval", clk_n - last_wr, 50);
                if (exp_iv == 49)
                    chk(clk_n - last_hs == 27, "R7 toggle to write", clk_n - last_hs, 27);
                last_wr = clk_n;
                wr_cnt++;
            end
            if (go_pulse) begin
                go_cnt++;
                go_clk = clk_n;
                chk(int'(go_addr) == BASE, "R5 entry address", go_addr, BASE);
            end
            if (err_led != led_prev) begin
                if (led_tog > 0)
                    chk(clk_n - last_led == HALF * div, "R1 blink half period", clk_n - last_led, HALF * div);
                led_tog++;
                last_led = clk_n;
            end
            if (hs_out != hs_prev) begin
                hs_tog++;
                last_hs = clk_n;
            end
            led_prev = err_led;
            hs_prev  = hs_out;
        end
    end

    // one loader run: stop_k < 0 means the stop pin never drops
    task automatic run_case(bit sec, int d, int mode, int dly, int stop_k, int sdel, int iv, int lim);
        rst = 1'b1; secure_open = sec; div = d; hs_mode = mode; hs_dly = dly; exp_iv = iv;
        keep_loading = (stop_k == 0) ? 1'b0 : 1'b1;
        wr_cnt = 0; go_cnt = 0; go_clk = 0; last_wr = 0; led_tog = 0; last_led = 0;
        hs_tog = 0; last_hs = 0; led_prev = 1'b0; hs_prev = 1'b0;
        repeat (4) @(negedge clk);
        chk(!ram_we && !go_pulse && !hs_out && !err_led && ext_addr == '0, "R10 reset state",
            {ram_we, go_pulse, hs_out, err_led, |ext_addr}, 0);
        rst = 1'b0;
        for (int c = 0; c < lim; c++) begin
            @(negedge clk);
            if (stop_k > 0 && wr_cnt == stop_k && clk_n - last_wr >= sdel) keep_loading = 1'b0;
            if (go_cnt > 0 && clk_n - go_clk > 60) break;
        end
    endtask

    initial begin
        #1520000;
        chk(1'b0, "watchdog expired", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R4 R6 R7 R9: tied handshake, full window
        run_case(1, 1, 0, 1, -1, 1, 49, 2000);
        chk(wr_cnt == NB, "R4 bytes until full", wr_cnt, NB);
        chk(go_cnt == 1, "R5 single start pulse", go_cnt, 1);
        chk(go_clk - last_wr == 17, "R4 pulse after last byte", go_clk - last_wr, 17);
        chk(hs_tog == NB, "R7 one toggle per cycle", hs_tog, NB);
        chk(led_tog == 0, "R9 led stays off", led_tog, 0);

        // R8: sparse machine-cycle enable
        run_case(1, 3, 0, 1, -1, 1, 147, 5000);
        chk(wr_cnt == NB, "R8 bytes with sparse enable", wr_cnt, NB);
        chk(go_cnt == 1, "R8 start pulse", go_cnt, 1);

        // R3: stop after every position
        for (int k = 0; k < NB; k++) begin
            run_case(1, 1, 0, 1, k, 1, 49, 2000);
            chk(wr_cnt == k, "R3 stop count", wr_cnt, k);
            chk(go_cnt == 1, "R3 start pulse after stop", go_cnt, 1);
            if (k > 0) chk(go_clk - last_wr == 50, "R5 pulse after stop", go_clk - last_wr, 50);
        end

        // R3: late-drop boundary, machine cycle 30 versus 31
        run_case(1, 1, 0, 1, 2, 46, 49, 2000);
        chk(wr_cnt == 2, "R3 drop at cycle 30 honoured", wr_cnt, 2);
        run_case(1, 1, 0, 1, 2, 47, 49, 2000);
        chk(wr_cnt == 3, "R3 drop at cycle 31 too late", wr_cnt, 3);

        // R7: fast host, slow host, silent host
        run_case(1, 1, 1, 3, -1, 1, 49, 2000);
        chk(wr_cnt == NB, "R7 fast host bytes", wr_cnt, NB);
        run_case(1, 1, 1, 40, -1, 1, -1, 4000);
        chk(wr_cnt == NB, "R7 slow host bytes", wr_cnt, NB);
        chk(go_cnt == 1, "R7 slow host start pulse", go_cnt, 1);
        run_case(1, 1, 2, 1, -1, 1, 0, 400);
        chk(wr_cnt == 0, "R7 silent host no write", wr_cnt, 0);
        chk(go_cnt == 0, "R7 silent host no start", go_cnt, 0);

        // R1: secured part
        for (int d = 1; d <= 2; d++) begin
            run_case(0, d, 0, 1, -1, 1, 0, 200);
            chk(wr_cnt == 0, "R1 no write when secured", wr_cnt, 0);
            chk(go_cnt == 0, "R1 no start when secured", go_cnt, 0);
            chk(led_tog >= 200 / (HALF * d) - 2, "R1 led blinks", led_tog, 200 / (HALF * d));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule